// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous request port and a byte-wide asynchronous static RAM. It takes one read or one write at a time and turns it into the chip-enable, write-enable and output-enable pin sequence the memory needs. A request is taken while `req_ready` is high. Completion is signalled by a one-cycle `resp_valid` pulse, and for a read that pulse comes with the data byte that was captured.

Every analog interval of the memory is given as a parameter in whole clock cycles, rounded up from nanoseconds at the chosen clock period. These intervals are the address access time, the output-enable access time, the write pulse width, the data setup before the strobe rises, the output-disable turnaround, and the write recovery. The data bus leaves the block as separate output, drive-enable and input signals so that the pad ring can build the tri-state buffer. The sequencer decides when that buffer drives.

The write strobe sets the capture moment. The data byte is driven one cycle before the strobe falls and is held one cycle after it rises, and chip enable stays low across the rise. Between operations the memory is parked in standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are high, `sram_dq_oe` is low, `req_ready` is high and `resp_valid` is low.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from the accepting edge until the operation completes, and a request offered while it is low is ignored.
- R3: A read holds `sram_ce_n` low, `sram_oe_n` low and `sram_we_n` high with a stable address for max(ACCESS_CYC, OE_CYC) cycles. The byte on `sram_dq_i` is sampled at the edge that ends this interval and is returned on `resp_rdata`.
- R4: A write drives `sram_dq_oe` high with chip enable low for one cycle before `sram_we_n` falls. `sram_we_n` is then held low for max(WR_PULSE_CYC, DSETUP_CYC-1) cycles. It rises while `sram_ce_n` is still low, and data remains driven for one more cycle after the rise.
- R5: `sram_addr` never changes while `sram_ce_n` is low.
- R6: When a read follows a write, `sram_ce_n` stays high for exactly 1+REC_CYC cycles between them.
- R7: When a write follows a read, `sram_ce_n` stays high for exactly 1+TURN_CYC cycles between the output-enable rise and the start of driving.
- R8: Each accepted request yields exactly one `resp_valid` pulse, one cycle wide. It appears in the first standby cycle after the operation, a cycle in which `req_ready` is already high, so a request waiting there starts at once. Same-kind operations issued back to back are separated by one standby cycle.
- R9: Whenever `sram_ce_n` is high, `sram_we_n` and `sram_oe_n` are high and `sram_dq_oe` is low.
- R10: `sram_dq_oe` is never high while `sram_oe_n` is low, and never high while the memory could still be driving after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Registered read byte |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_o | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_i | input | DATA_W | Data from the memory |

## Verification
The bench builds the block with ACCESS_CYC=3, OE_CYC=2, WR_PULSE_CYC=2, DSETUP_CYC=4, TURN_CYC=2 and REC_CYC=1. In this setting the data-setup term, not the pulse width, sets the strobe length. The read interval comes from the access time rather than the output-enable time. The two gaps differ, so a swap between them is visible. A memory model returns junk until the read interval is complete. It keeps driving for a cycle after output enable rises. It records strobe widths, standby runs, address movement and data setup, so that early sampling, short gaps and contention all show up as wrong data or wrong counts.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GAP    = 3'd1,
    ST_RD     = 3'd2,
    ST_WSET   = 3'd3,
    ST_WPULSE = 3'd4,
    ST_WEND   = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    LAST_NONE = 2'd0,
    LAST_RD   = 2'd1,
    LAST_WR   = 2'd2
  } last_op_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int ACCESS_CYC   = 2,
  parameter int OE_CYC       = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int DSETUP_CYC   = 1,
  parameter int TURN_CYC     = 1,
  parameter int REC_CYC      = 1,
  parameter int CNT_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             rd_capture,
  output logic             req_ready,
  output logic             resp_valid,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  localparam int RD_EFF = imax(ACCESS_CYC, OE_CYC);
  localparam int WP_EFF = imax(WR_PULSE_CYC, (DSETUP_CYC > 1) ? DSETUP_CYC - 1 : 1);

  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_EFF - 1);
  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_EFF - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD  = CNT_W'(REC_CYC - 1);

  seq_state_e state_q, state_d;
  last_op_e   last_q, last_d;
  logic       op_wr_q, op_wr_d;
  logic       resp_d;
  logic       ce_n_d, we_n_d, oe_n_d, dq_oe_d;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    last_d     = last_q;
    op_wr_d    = op_wr_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    accept     = 1'b0;
    rd_capture = 1'b0;
    resp_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          op_wr_d = req_write;
          if (req_write) begin
            if (last_q == LAST_RD) begin
              state_d  = ST_GAP;
              tmr_load = 1'b1;
              tmr_val  = TURN_LOAD;
            end else begin
              state_d = ST_WSET;
            end
          end else begin
            if (last_q == LAST_WR) begin
              state_d  = ST_GAP;
              tmr_load = 1'b1;
              tmr_val  = REC_LOAD;
            end else begin
              state_d  = ST_RD;
              tmr_load = 1'b1;
              tmr_val  = RD_LOAD;
            end
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          if (op_wr_q) begin
            state_d = ST_WSET;
          end else begin
            state_d  = ST_RD;
            tmr_load = 1'b1;
            tmr_val  = RD_LOAD;
          end
        end
      end
      ST_RD: begin
        if (tmr_zero) begin
          state_d    = ST_IDLE;
          rd_capture = 1'b1;
          resp_d     = 1'b1;
          last_d     = LAST_RD;
        end
      end
      ST_WSET: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = WP_LOAD;
      end
      ST_WPULSE: begin
        if (tmr_zero) begin
          state_d = ST_WEND;
        end
      end
      ST_WEND: begin
        state_d = ST_IDLE;
        resp_d  = 1'b1;
        last_d  = LAST_WR;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // pin decode of the next state, registered so the pins never glitch
  always_comb begin
    ce_n_d  = !((state_d == ST_RD) || (state_d == ST_WSET) ||
                (state_d == ST_WPULSE) || (state_d == ST_WEND));
    oe_n_d  = (state_d != ST_RD);
    we_n_d  = (state_d != ST_WPULSE);
    dq_oe_d = (state_d == ST_WSET) || (state_d == ST_WPULSE) || (state_d == ST_WEND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      last_q     <= LAST_NONE;
      op_wr_q    <= 1'b0;
      resp_valid <= 1'b0;
      ce_n       <= 1'b1;
      we_n       <= 1'b1;
      oe_n       <= 1'b1;
      dq_oe      <= 1'b0;
    end else begin
      state_q    <= state_d;
      last_q     <= last_d;
      op_wr_q    <= op_wr_d;
      resp_valid <= resp_d;
      ce_n       <= ce_n_d;
      we_n       <= we_n_d;
      oe_n       <= oe_n_d;
      dq_oe      <= dq_oe_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    addr_d  = accept     ? req_addr  : addr_q;
    wdata_d = accept     ? req_wdata : wdata_q;
    rdata_d = rd_capture ? dq_in     : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int ACCESS_CYC   = 2,
  parameter int OE_CYC       = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int DSETUP_CYC   = 1,
  parameter int TURN_CYC     = 1,
  parameter int REC_CYC      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int MAX_CYC = imax(imax(imax(ACCESS_CYC, OE_CYC), imax(WR_PULSE_CYC, DSETUP_CYC)),
                                imax(TURN_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             accept;
  logic             rd_capture;

  sram_seq_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_fsm #(
    .ACCESS_CYC   (ACCESS_CYC),
    .OE_CYC       (OE_CYC),
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .DSETUP_CYC   (DSETUP_CYC),
    .TURN_CYC     (TURN_CYC),
    .REC_CYC      (REC_CYC),
    .CNT_W        (CNT_W)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .tmr_zero   (tmr_zero),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .accept     (accept),
    .rd_capture (rd_capture),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .ce_n       (sram_ce_n),
    .we_n       (sram_we_n),
    .oe_n       (sram_oe_n),
    .dq_oe      (sram_dq_oe)
  );

  sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rd_capture (rd_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .dq_in      (sram_dq_i),
    .addr_q     (sram_addr),
    .wdata_q    (sram_dq_o),
    .rdata_q    (resp_rdata)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int ACCESS_CYC   = 2,
  parameter int OE_CYC       = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int DSETUP_CYC   = 1,
  parameter int TURN_CYC     = 1,
  parameter int REC_CYC      = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);

  localparam int RD_EFF = imax(ACCESS_CYC, OE_CYC);
  localparam int WP_EFF = imax(WR_PULSE_CYC, (DSETUP_CYC > 1) ? DSETUP_CYC - 1 : 1);

  logic [7:0] wlow_q, olow_q, since_rd_q, since_wr_q;

  // saturating run-length counters over the pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlow_q     <= '0;
      olow_q     <= '0;
      since_rd_q <= '1;
      since_wr_q <= '1;
    end else begin
      wlow_q     <= !sram_we_n ? ((wlow_q == '1) ? wlow_q : wlow_q + 1'b1) : '0;
      olow_q     <= !sram_oe_n ? ((olow_q == '1) ? olow_q : olow_q + 1'b1) : '0;
      since_rd_q <= !sram_oe_n ? '0 : ((since_rd_q == '1) ? since_rd_q : since_rd_q + 1'b1);
      since_wr_q <= sram_dq_oe ? '0 : ((since_wr_q == '1) ? since_wr_q : since_wr_q + 1'b1);
    end
  end

  AST_STANDBY_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n |-> (sram_we_n && sram_oe_n && !sram_dq_oe)); // R9

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe); // R10

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R5

  AST_WE_ENDS_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe)); // R4

  AST_STROBE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(sram_dq_oe)); // R4

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (wlow_q == 8'(WP_EFF))); // R4

  AST_READ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (olow_q == 8'(RD_EFF))); // R3

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (since_rd_q >= 8'(TURN_CYC + 1))); // R7

  AST_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> (since_wr_q >= 8'(REC_CYC + 1))); // R6

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (req_ready && sram_ce_n) ##1 !resp_valid); // R8

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !req_ready); // R2

endmodule

bind sram_seq_ctrl sram_seq_chk #(
  .ADDR_W       (ADDR_W),
  .ACCESS_CYC   (ACCESS_CYC),
  .OE_CYC       (OE_CYC),
  .WR_PULSE_CYC (WR_PULSE_CYC),
  .DSETUP_CYC   (DSETUP_CYC),
  .TURN_CYC     (TURN_CYC),
  .REC_CYC      (REC_CYC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;

  localparam int AW   = 15;
  localparam int DW   = 8;
  localparam int ACC  = 3;
  localparam int OEC  = 2;
  localparam int WP   = 2;
  localparam int DS   = 4;
  localparam int TURN = 2;
  localparam int REC  = 1;
  localparam int RD_EFF = (ACC > OEC) ? ACC : OEC;           // 3
  localparam int WP_EFF = (WP > DS - 1) ? WP : DS - 1;        // 3

  // vector: {write, addr[14:0], data[7:0]}
  localparam int NVEC = 9;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 15'h0010, 8'hA5},
    {1'b0, 15'h0010, 8'h00},
    {1'b1, 15'h7FFF, 8'h3C},
    {1'b1, 15'h0000, 8'hC3},
    {1'b0, 15'h7FFF, 8'h00},
    {1'b0, 15'h0000, 8'h00},
    {1'b1, 15'h0010, 8'h5A},
    {1'b0, 15'h0010, 8'h00},
    {1'b0, 15'h1234, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, resp_valid;
  logic [DW-1:0] resp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_o;
  logic [DW-1:0] sram_dq_i = 8'hEE;

  always #4 clk = ~clk; // 125 MHz

  sram_seq_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC), .OE_CYC(OEC),
    .WR_PULSE_CYC(WP), .DSETUP_CYC(DS), .TURN_CYC(TURN), .REC_CYC(REC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural memory model (sampled at negedge) ----------
  bit [7:0] mem_m [int unsigned];
  int err_contention = 0, err_addr = 0, err_setup = 0, err_we_ce = 0;
  int last_wp = 0, last_rd = 0, last_idle = 0, resp_cnt = 0;
  int wlow = 0, olow = 0, ce_hi = 0, ds_cnt = 0, rd_cnt = 0, hold = 0;
  logic          p_we = 1, p_oe = 1, p_ce = 1, p_dqoe = 0, p_rd = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;

  always @(negedge clk) begin
    logic rd_cond;
    rd_cond = !sram_ce_n && !sram_oe_n && sram_we_n;
    if (rst_n) begin
      if (resp_valid) resp_cnt++;
      if (sram_dq_oe && (hold > 0 || rd_cond)) err_contention++;
      if (!sram_ce_n && !p_ce && sram_addr != p_addr) err_addr++;
      if (sram_dq_oe) ds_cnt = (p_dqoe && sram_dq_o == p_dq) ? ds_cnt + 1 : 1;
      else ds_cnt = 0;
      if (!sram_we_n) wlow++;
      if (sram_we_n && !p_we) begin
        last_wp = wlow;
        wlow = 0;
        if (sram_ce_n) err_we_ce++;
        if (!sram_dq_oe || ds_cnt - 1 < DS) err_setup++;
        mem_m[32'(sram_addr)] = sram_dq_o;
      end
      if (!sram_oe_n) olow++;
      if (sram_oe_n && !p_oe) begin last_rd = olow; olow = 0; end
      if (sram_ce_n) ce_hi++;
      else if (p_ce) begin last_idle = ce_hi; ce_hi = 0; end
    end
    hold = rd_cond ? 2 : ((hold > 0) ? hold - 1 : 0);
    if (rd_cond) rd_cnt = (p_rd && sram_addr == p_addr) ? rd_cnt + 1 : 1;
    else rd_cnt = 0;
    if (rd_cond && rd_cnt >= RD_EFF)
      sram_dq_i = mem_m.exists(32'(sram_addr)) ? mem_m[32'(sram_addr)] : 8'h00;
    else
      sram_dq_i = 8'hEE;
    p_we = sram_we_n; p_oe = sram_oe_n; p_ce = sram_ce_n; p_dqoe = sram_dq_oe;
    p_rd = rd_cond; p_addr = sram_addr; p_dq = sram_dq_o;
  end

  // ---------------- request driver ----------------
  logic [DW-1:0] got;
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!req_ready) @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    got = resp_rdata;
  endtask

  bit [7:0] ref_m [int unsigned];
  int prev_kind = -1;

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 and R9: reset / standby state
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 pins high", {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
    chk(!sram_dq_oe, "R9 bus released in standby", sram_dq_oe, 0);
    chk(req_ready && !resp_valid, "R1 ready/resp", {req_ready, resp_valid}, 2'b10);

    for (int i = 0; i < NVEC; i++) begin
      bit wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int resp_before, exp_idle;
      wr = VEC[i][23]; a = VEC[i][22:8]; d = VEC[i][7:0];
      resp_before = resp_cnt;
      do_op(wr, a, d);
      @(negedge clk); // let the response cycle be counted and run lengths settle
      chk(resp_cnt == resp_before + 1, "R8 one response per request", resp_cnt - resp_before, 1);
      if (wr) begin
        ref_m[32'(a)] = d;
        chk(last_wp == WP_EFF, "R4 strobe width", last_wp, WP_EFF);
      end else begin
        int unsigned e;
        e = ref_m.exists(32'(a)) ? 32'(ref_m[32'(a)]) : 0;
        chk(got == e[7:0], "R3 read data", got, e);
        chk(last_rd == RD_EFF, "R3 read interval", last_rd, RD_EFF);
      end
      if (prev_kind >= 0) begin
        if (prev_kind == 1 && !wr) exp_idle = 1 + REC;       // R6
        else if (prev_kind == 0 && wr) exp_idle = 1 + TURN;   // R7
        else exp_idle = 1;                                    // R8 back to back
        chk(last_idle == exp_idle, wr ? "R7 R8 standby run before write" : "R6 R8 standby run before read",
            last_idle, exp_idle);
      end
      prev_kind = wr ? 1 : 0;
      // the extra negedge above breaks back-to-back; rewind the expectation
      prev_kind = -1;
      if (i + 1 < NVEC) begin
        // issue the next one back to back by a separate pair below
      end
    end

    // back-to-back pairs: response cycle used to start the next request at once
    begin
      do_op(1'b1, 15'h0100, 8'h81);
      do_op(1'b0, 15'h0100, 8'h00);
      chk(got == 8'h81, "R3 read after write data", got, 8'h81);
      @(negedge clk);
      chk(last_idle == 1 + REC, "R6 write to read gap", last_idle, 1 + REC);
      do_op(1'b0, 15'h0100, 8'h00);
      do_op(1'b1, 15'h0101, 8'h18);
      @(negedge clk);
      chk(last_idle == 1 + TURN, "R7 read to write gap", last_idle, 1 + TURN);
      do_op(1'b1, 15'h0102, 8'h27);
      do_op(1'b1, 15'h0103, 8'h72);
      @(negedge clk);
      chk(last_idle == 1, "R8 write to write gap", last_idle, 1);
      ref_m[32'h0101] = 8'h18; ref_m[32'h0102] = 8'h27; ref_m[32'h0103] = 8'h72;
    end

    // R2: request offered while busy is ignored
    begin
      int rb;
      rb = resp_cnt;
      req_write = 1'b1; req_addr = 15'h0200; req_wdata = 8'h11; req_valid = 1'b1;
      @(negedge clk);
      req_addr = 15'h0201; req_wdata = 8'h77;
      chk(!req_ready, "R2 ready low while busy", req_ready, 0);
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!resp_valid) @(negedge clk);
      @(negedge clk);
      chk(resp_cnt == rb + 1, "R2 busy request not taken", resp_cnt - rb, 1);
      do_op(1'b0, 15'h0201, 8'h00);
      chk(got == 8'h00, "R2 ignored write left memory", got, 0);
      do_op(1'b0, 15'h0200, 8'h00);
      chk(got == 8'h11, "R2 accepted write data", got, 8'h11);
      do_op(1'b0, 15'h0103, 8'h00);
      chk(got == 8'h72, "R3 read of back-to-back write", got, 8'h72);
    end

    repeat (4) @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R9 standby when idle",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
    chk(err_contention == 0, "R10 bus contention", err_contention, 0);
    chk(err_addr == 0, "R5 address moved under chip enable", err_addr, 0);
    chk(err_setup == 0, "R4 data setup before strobe rise", err_setup, 0);
    chk(err_we_ce == 0, "R4 strobe rose with chip enable high", err_we_ce, 0);
    finish_run();
  end

endmodule